// File: doc/BRIEF.md
# DDS programming word loader

This block is the host-facing register front end of a direct digital synthesizer. A host writes a 40-bit programming word in one of two ways. It can send five bytes over an 8-bit parallel bus, or it can send forty single bits on one serial data line. In both cases the host advances the transfer with a word clock. A separate update strobe then copies the assembled word into the active control registers. Those registers drive the synthesizer core with a 32-bit frequency tuning word, a 5-bit phase offset, a reference-multiplier enable and a power-down flag.

The block always leaves reset in parallel mode. A special control byte, written as the first parallel byte, moves it into serial mode. Serial mode then holds until the next reset. Reset clears the active registers, but the assembly register keeps its contents through reset. The word clock and the update strobe arrive asynchronously, so each passes through a two-flop synchronizer and a rising-edge detector clocked by the system clock.

Top module: `dds_word_loader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, the outputs read as follows:
  - `serial_mode` = 0
  - `power_down` = 0
  - `mult_en` = 0
  - `phase_offset` = 0
  - `tuning_word` = 0
- R2: Reset leaves the 40-bit assembly register as it was. An update strobe sent after reset, with no new load in between, applies the word that was loaded before reset.
- R3: In parallel mode, each word clock rising edge stores `par_data` into the next byte slot.
  - The first byte is the control byte and fills word bits [39:32].
  - The next four bytes fill the tuning word, most significant byte first: [31:24], [23:16], [15:8], [7:0].
  - Control byte fields: bit 0 is the multiplier enable, bit 1 is the guard bit, bit 2 is power-down, and bits [7:3] are the phase offset.
- R4: After five bytes the slot pointer saturates, and any further parallel bytes are ignored. An update strobe sends the pointer back to the control byte slot. Byte slots that were not rewritten since the last update keep their old contents.
- R5: The outputs change only on an update strobe. A word clock edge by itself leaves all outputs unchanged.
- R6: In parallel mode, an update whose control byte has low bits [2:0] = 011 sets `serial_mode` to 1 and leaves the other outputs unchanged.
- R7: The power-down flag follows control bit 2 on each applied update. A control byte with bits [2:1] = 10 sets it, and one with bits [2:1] = 00 clears it.
- R8: In serial mode, each word clock rising edge shifts `ser_data` into the word, least significant bit first. After 40 edges, the first bit received is tuning word bit 0, and bits 32 to 39 form the control byte.
- R9: An update whose word has bit 33 (control bit 1, the guard bit) set applies nothing to the tuning, phase, multiplier or power-down outputs. This holds in both modes, except for the mode switch described in R6.
- R10: Once set, `serial_mode` stays at 1 until reset, whatever words are applied. Reset returns the block to parallel mode.
- R11: Each strobe passes through two synchronizer flops and an edge register, so an update strobe rising before clock edge 1 changes the outputs at clock edge 3. No edge is detected in the first cycle after reset is released. A strobe line held high across reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| word_clk | input | 1 | Asynchronous word clock; a rising edge loads one byte or one bit |
| update_strobe | input | 1 | Asynchronous update strobe; a rising edge applies the assembled word |
| par_data | input | 8 | Parallel byte input |
| ser_data | input | 1 | Serial bit input |
| tuning_word | output | 32 | Active frequency tuning word |
| phase_offset | output | 5 | Active phase offset |
| mult_en | output | 1 | Reference clock multiplier enable |
| power_down | output | 1 | Power-down flag |
| serial_mode | output | 1 | 1 when serial loading is selected |

## Verification
The assertions assume the following about the inputs:
- `par_data` and `ser_data` stay stable from the word clock's rising edge until the synchronized edge has been taken.
- Each strobe level lasts several system clocks, so no edge is lost in the synchronizer.
- Reset lasts at least five cycles.

The bench holds every strobe high for four clocks and low for four. It changes data only together with a new word clock pulse, and it holds reset for six cycles. Within those rules it sweeps every phase and multiplier combination, all eight low-bit control patterns, partial and oversized parallel loads, and serial words with the guard bit both clear and set.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = 5;
    localparam int WORD_W  = BYTE_W * NBYTES;
    localparam int FTW_W   = 32;
    localparam int PHASE_W = 5;
    localparam int PTR_W   = $clog2(NBYTES + 1);

    // Control byte, occupies word bits [39:32]
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pdn;
        logic               guard;
        logic               mult;
    } ctl_t;

    typedef struct packed {
        ctl_t             ctl;
        logic [FTW_W-1:0] ftw;
    } word_t;

    typedef enum logic {MODE_PAR = 1'b0, MODE_SER = 1'b1} mode_t;

    localparam logic [2:0] SER_KEY = 3'b011;

    function automatic logic is_ser_key(ctl_t c);
        return {c.pdn, c.guard, c.mult} == SER_KEY;
    endfunction

    function automatic logic may_apply(ctl_t c);
        return !c.guard;
    endfunction
endpackage

// File: rtl/dds_edge_sync.sv
module dds_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Reset to high so a line held high through reset yields no edge
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/dds_assembler.sv
module dds_assembler
    import dds_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wclk_rise,
    input  logic              upd_rise,
    input  mode_t             mode,
    input  logic [BYTE_W-1:0] bus,
    input  logic              ser_bit,
    output word_t             word
);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NBYTES);

    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] nxt;
    logic [NBYTES-1:0] lane_hit;

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane_hit[g] = (ptr == PTR_W'(g));
    end

    always_comb begin
        nxt = shreg;
        if (mode == MODE_SER) begin
            nxt = {ser_bit, shreg[WORD_W-1:1]};
        end else begin
            for (int i = 0; i < NBYTES; i++) begin
                if (lane_hit[i]) nxt[(NBYTES-1-i)*BYTE_W +: BYTE_W] = bus;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (upd_rise) begin
            ptr <= '0;
        end else if (wclk_rise && mode == MODE_PAR && ptr < PTR_END) begin
            ptr <= ptr + 1'b1;
        end
    end

    // Assembly register is deliberately not reset
    always_ff @(posedge clk) begin
        if (wclk_rise && !upd_rise) shreg <= nxt;
    end

    assign word = word_t'(shreg);
endmodule

// File: rtl/dds_ctrl_regs.sv
module dds_ctrl_regs
    import dds_loader_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_rise,
    input  word_t              word,
    output mode_t              mode,
    output logic [FTW_W-1:0]   ftw,
    output logic [PHASE_W-1:0] phase,
    output logic               mult,
    output logic               pdn
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= MODE_PAR;
            ftw   <= '0;
            phase <= '0;
            mult  <= 1'b0;
            pdn   <= 1'b0;
        end else if (upd_rise) begin
            if (mode == MODE_PAR && is_ser_key(word.ctl)) begin
                mode <= MODE_SER;
            end else if (may_apply(word.ctl)) begin
                ftw   <= word.ftw;
                phase <= word.ctl.phase;
                mult  <= word.ctl.mult;
                pdn   <= word.ctl.pdn;
            end
        end
    end
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader
    import dds_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               word_clk,
    input  logic               update_strobe,
    input  logic [BYTE_W-1:0]  par_data,
    input  logic               ser_data,
    output logic [FTW_W-1:0]   tuning_word,
    output logic [PHASE_W-1:0] phase_offset,
    output logic               mult_en,
    output logic               power_down,
    output logic               serial_mode
);
    logic  wclk_rise;
    logic  upd_rise;
    mode_t mode;
    word_t asm_word;

    dds_edge_sync #(.STAGES(SYNC_STAGES)) u_wclk_sync (
        .clk(clk), .rst(rst), .din(word_clk), .rise(wclk_rise)
    );

    dds_edge_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
        .clk(clk), .rst(rst), .din(update_strobe), .rise(upd_rise)
    );

    dds_assembler u_asm (
        .clk(clk), .rst(rst), .wclk_rise(wclk_rise), .upd_rise(upd_rise),
        .mode(mode), .bus(par_data), .ser_bit(ser_data), .word(asm_word)
    );

    dds_ctrl_regs u_regs (
        .clk(clk), .rst(rst), .upd_rise(upd_rise), .word(asm_word),
        .mode(mode), .ftw(tuning_word), .phase(phase_offset),
        .mult(mult_en), .pdn(power_down)
    );

    assign serial_mode = (mode == MODE_SER);
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk
    import dds_loader_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wclk_rise,
    input logic               upd_rise,
    input word_t              word,
    input logic [FTW_W-1:0]   tuning_word,
    input logic [PHASE_W-1:0] phase_offset,
    input logic               mult_en,
    input logic               power_down,
    input logic               serial_mode
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!serial_mode && !power_down && !mult_en &&
                        phase_offset == '0 && tuning_word == '0));

    p_recover_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!upd_rise && !wclk_rise));

    p_single_edge_r11: assert property (@(posedge clk) disable iff (rst)
        upd_rise |=> !upd_rise);

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !upd_rise |=> ($stable(tuning_word) && $stable(phase_offset) &&
                       $stable(mult_en) && $stable(power_down) && $stable(serial_mode)));

    p_apply_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_rise && !word.ctl.guard) |=>
            (tuning_word == $past(word.ftw) && power_down == $past(word.ctl.pdn) &&
             phase_offset == $past(word.ctl.phase) && mult_en == $past(word.ctl.mult)));

    p_guard_r9: assert property (@(posedge clk) disable iff (rst)
        (upd_rise && word.ctl.guard) |=>
            ($stable(tuning_word) && $stable(phase_offset) &&
             $stable(mult_en) && $stable(power_down)));

    p_switch_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_rise && !serial_mode && is_ser_key(word.ctl)) |=> serial_mode);

    p_sticky_serial_r10: assert property (@(posedge clk) disable iff (rst)
        serial_mode |=> serial_mode);
endmodule

bind dds_word_loader dds_word_loader_chk u_chk (
    .clk(clk), .rst(rst), .wclk_rise(wclk_rise), .upd_rise(upd_rise),
    .word(asm_word), .tuning_word(tuning_word), .phase_offset(phase_offset),
    .mult_en(mult_en), .power_down(power_down), .serial_mode(serial_mode)
);

// File: tb/sim_dds_word_loader.sv
module sim_dds_word_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wclk = 1'b0;
    logic        fqud = 1'b0;
    logic [7:0]  bus = 8'h00;
    logic        ser = 1'b0;
    logic [31:0] tuning_word;
    logic [4:0]  phase_offset;
    logic        mult_en, power_down, serial_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    logic [39:0] exp_asm;
    int          exp_ptr = 0;
    logic [31:0] exp_ftw = '0;
    logic [4:0]  exp_phase = '0;
    logic        exp_mult = 0, exp_pdn = 0, exp_ser = 0;

    always #10 clk = ~clk;

    dds_word_loader u0 (
        .clk(clk), .rst(rst), .word_clk(wclk), .update_strobe(fqud),
        .par_data(bus), .ser_data(ser), .tuning_word(tuning_word),
        .phase_offset(phase_offset), .mult_en(mult_en),
        .power_down(power_down), .serial_mode(serial_mode)
    );

    task automatic check(input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "tuning_word", {8'h0, tuning_word}, {8'h0, exp_ftw});
        check(req, "phase_offset", {35'h0, phase_offset}, {35'h0, exp_phase});
        check(req, "mult_en", {39'h0, mult_en}, {39'h0, exp_mult});
        check(req, "power_down", {39'h0, power_down}, {39'h0, exp_pdn});
        check(req, "serial_mode", {39'h0, serial_mode}, {39'h0, exp_ser});
    endtask

    task automatic model_reset();
        exp_ptr = 0; exp_ftw = '0; exp_phase = '0;
        exp_mult = 0; exp_pdn = 0; exp_ser = 0;
    endtask

    task automatic model_update();
        logic [7:0] c;
        c = exp_asm[39:32];
        if (!exp_ser && c[2:0] == 3'b011) begin
            exp_ser = 1;
        end else if (!c[1]) begin
            exp_ftw = exp_asm[31:0]; exp_phase = c[7:3];
            exp_mult = c[0]; exp_pdn = c[2];
        end
        exp_ptr = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; wclk = 0; fqud = 0;
        repeat (6) @(negedge clk);
        rst = 0;
        model_reset();
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_w(input logic [7:0] b, input logic s);
        @(negedge clk);
        bus = b; ser = s; wclk = 1;
        repeat (4) @(negedge clk);
        wclk = 0;
        repeat (4) @(negedge clk);
        if (exp_ser) exp_asm = {s, exp_asm[39:1]};
        else if (exp_ptr < 5) begin
            exp_asm[(4-exp_ptr)*8 +: 8] = b;
            exp_ptr++;
        end
    endtask

    task automatic pulse_u();
        @(negedge clk);
        fqud = 1;
        repeat (4) @(negedge clk);
        fqud = 0;
        repeat (4) @(negedge clk);
        model_update();
    endtask

    task automatic load_par(input logic [39:0] w);
        for (int i = 4; i >= 0; i--) pulse_w(w[i*8 +: 8], 1'b0);
    endtask

    task automatic load_ser(input logic [39:0] w);
        for (int i = 0; i < 40; i++) pulse_w(8'h00, w[i]);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [39:0] w;
        do_reset();
        check_all("R1");

        // R3: sweep every phase and multiplier value through parallel loads
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 2; m++) begin
                w[31:0]  = 32'h9E37_79B9 * (p * 2 + m + 1);
                w[39:32] = {p[4:0], 1'b0, 1'b0, m[0]};
                load_par(w);
                pulse_u();
                check_all("R3");
            end
        end

        // R5: word clock without update changes nothing
        pulse_w(8'hF8, 1'b0);
        check_all("R5");

        // R4: update restarts pointer, extra bytes ignored, partial load
        pulse_u();
        check_all("R4");
        load_par(40'h51_0102_0304);
        pulse_w(8'hAA, 1'b0);
        pulse_u();
        check_all("R4");
        load_par(40'h88_A1B2_C3D4);
        pulse_u();
        check_all("R4");
        pulse_w(8'h20, 1'b0);
        pulse_w(8'h7E, 1'b0);
        pulse_u();
        check_all("R4");

        // R11: latency of update strobe, three clock edges
        load_par(40'hC0_DEAD_BEEF);
        @(negedge clk);
        fqud = 1;
        @(negedge clk);
        check("R11", "edge1 unchanged", {8'h0, tuning_word}, {8'h0, exp_ftw});
        @(negedge clk);
        check("R11", "edge2 unchanged", {8'h0, tuning_word}, {8'h0, exp_ftw});
        @(negedge clk);
        check("R11", "edge3 applied", {8'h0, tuning_word}, 40'h00_DEAD_BEEF);
        repeat (2) @(negedge clk);
        fqud = 0;
        repeat (4) @(negedge clk);
        model_update();
        check_all("R11");

        // R7: power-down set by 10x, released by 00x
        load_par(40'h2C_0000_1111);
        pulse_u();
        check_all("R7");
        check("R7", "pdn set", {39'h0, power_down}, 40'h1);
        load_par(40'h28_0000_2222);
        pulse_u();
        check("R7", "pdn clear", {39'h0, power_down}, 40'h0);
        check_all("R7");

        // R2: assembly register survives reset
        load_par(40'h49_1234_5678);
        do_reset();
        check_all("R1");
        pulse_u();
        check_all("R2");
        check("R2", "tuning", {8'h0, tuning_word}, 40'h00_1234_5678);

        // R11: strobe held high across reset gives no edge
        @(negedge clk);
        fqud = 1; rst = 1;
        repeat (6) @(negedge clk);
        rst = 0;
        model_reset();
        repeat (6) @(negedge clk);
        check_all("R11");
        fqud = 0;
        repeat (4) @(negedge clk);

        // R6 / R9: all eight low control patterns in parallel mode
        for (int k = 0; k < 8; k++) begin
            do_reset();
            w = {5'h15, k[2:0], 32'h0F0F_0000 + 32'(k)};
            load_par(w);
            pulse_u();
            check_all(k == 3 ? "R6" : "R9");
        end

        // R8 / R9 / R10: serial loading
        do_reset();
        load_par(40'h03_0000_0000);
        pulse_u();
        check_all("R6");
        for (int i = 0; i < 6; i++) begin
            w[31:0]  = 32'h8421_1248 ^ (32'h0101_0101 * (i + 3));
            w[39:32] = {5'(i * 7), i[0], (i == 2 || i == 4), 1'b1};
            if (i == 5) w[39:32] = 8'h03;
            load_ser(w);
            pulse_u();
            check_all((i == 2 || i == 4) ? "R9" : "R8");
        end
        check("R10", "serial sticky", {39'h0, serial_mode}, 40'h1);
        do_reset();
        check("R10", "reset to parallel", {39'h0, serial_mode}, 40'h0);
        check_all("R1");

        done = 1;
        finish_run();
    end
endmodule